// File: doc/BRIEF.md
# Commit-Stage Flush-After-Retire Controller

This block sits beside the commit stage of an out-of-order core and owns, for each hardware thread, the decision of whether the oldest instruction may retire and when the thread's in-flight work must be thrown away. Some instructions must be followed by a complete pipeline flush once they retire. The controller handles these in two steps. In the first cycle, the flagged instruction retires and the thread stops committing. In the following cycle, a squash of every in-flight instruction of that thread is issued from a dedicated pending state. Fetch also receives a restart tag that carries the sequence number of the instruction that caused the flush.

Each thread runs its own state machine with five states, with these encodings: IDLE=0, ROB_SQUASH=1, TRAP_WAIT=2, FTRAP_WAIT=3 and FLUSH_PEND=4. The transitions are as follows:
- IDLE goes to FLUSH_PEND when a flagged head retires.
- IDLE goes to TRAP_WAIT on a raised trap.
- IDLE goes to FTRAP_WAIT on a raised fetch-side trap.
- Any state goes to ROB_SQUASH whenever a squash is issued.
- ROB_SQUASH goes to IDLE when the reorder buffer reports that its squash is done.
- Any state goes to IDLE on takeover.

Squash sources are ranked as follows: a trap squash first, then a context-write squash, then the pending flush. The causing instruction's sequence number is latched per thread. It is cleared when any squash is issued, on takeover and on reset.

Top module: `commit_flush_ctrl`

## Requirements
- R1: After reset, every thread is in IDLE (0) with commit enabled and no squash. Takeover returns a thread to IDLE and drops any latched flush, so no flush squash follows it. During the takeover cycle, the thread neither commits nor squashes.
- R2: When a thread is IDLE with no squash or trap input and its head is valid and flagged, the head retires in that cycle. The thread enters FLUSH_PEND (4) on the next cycle, and nothing retires while it is in FLUSH_PEND.
- R3: In the cycle spent in FLUSH_PEND with no trap or context-write squash, the controller pulses squash_all, activity and restart_vld for exactly one cycle. restart_seq carries the latched sequence number. The thread then moves to ROB_SQUASH (1).
- R4: A thread never retires and squashes in the same cycle.
- R5: A trap squash outranks a context-write squash, and both outrank the pending flush. Such a squash asserts squash_all with restart_vld and activity low, and clears the latched tag. In IDLE, it also blocks the retire of a flagged head, so no flush becomes pending.
- R6: In ROB_SQUASH, commit stays off until rob_squash_done, after which the thread returns to IDLE.
- R7: trap_raise moves an IDLE thread to TRAP_WAIT (2), and ftrap_raise moves it to FTRAP_WAIT (3). Commit is off in both states and in the raising cycle. A trap squash moves the thread from either state to ROB_SQUASH.
- R8: Threads are independent: one thread in FLUSH_PEND does not stop another from retiring.
- R9: A new flush request while a tag is still latched must name the same sequence number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| takeover | input | 1 | Returns all threads to IDLE and clears latched tags |
| head_valid | input | THREADS | Head of reorder buffer holds an instruction |
| head_flush | input | THREADS | Head instruction requires a flush after it retires |
| head_seq | input | THREADS*SEQ_W | Head instruction sequence number, per thread |
| trap_raise | input | THREADS | Trap raised, wait for trap squash |
| ftrap_raise | input | THREADS | Fetch-side trap raised, wait for trap squash |
| trap_squash | input | THREADS | Trap squash request (highest rank) |
| tc_squash | input | THREADS | Context-write squash request |
| rob_squash_done | input | THREADS | Reorder buffer finished squashing |
| commit_en | output | THREADS | Thread may retire this cycle |
| retire | output | THREADS | Head retires this cycle |
| squash_all | output | THREADS | Squash every in-flight instruction of the thread |
| restart_vld | output | THREADS | Restart tag valid (flush squash only) |
| restart_seq | output | THREADS*SEQ_W | Sequence number of the causing instruction |
| activity | output | THREADS | Activity pulse for a flush squash |
| thread_state | output | THREADS*3 | Per-thread state encoding |

## Verification
Retire and squash are the two functions that could collide for one thread in one cycle. This happens when a flagged head sits in the reorder buffer while a trap or context-write squash arrives, and it also happens on the cycle after a flagged retire, when a younger head is already valid. The bench provokes both cases. It checks that retire stays low whenever squash_all is high, and that the squash rank decides which one wins. A scoreboard queue holds the expected squash pulses with their restart tag, and every observed pulse is compared against it in order.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_ROB_SQUASH = 3'd1,
        ST_TRAP_WAIT  = 3'd2,
        ST_FTRAP_WAIT = 3'd3,
        ST_FLUSH_PEND = 3'd4
    } thr_state_e;

    localparam int STATE_W = 3;
endpackage

// File: rtl/cfc_tag_latch.sv
module cfc_tag_latch #(
    parameter int SEQ_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [SEQ_W-1:0] cap_seq,
    input  logic             clear,
    output logic             held_vld,
    output logic [SEQ_W-1:0] held_seq
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_vld <= 1'b0;
            held_seq <= '0;
        end else if (clear) begin
            held_vld <= 1'b0;
            held_seq <= '0;
        end else if (capture) begin
            held_vld <= 1'b1;
            held_seq <= cap_seq;
        end
    end

    // A repeat request while a tag is held must name the same instruction
    assert_tag_conflict_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && held_vld && !clear) |-> (cap_seq == held_seq));

    assert_clear_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !held_vld);
endmodule

// File: rtl/cfc_thread_fsm.sv
module cfc_thread_fsm
    import cfc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       takeover,
    input  logic       head_valid,
    input  logic       head_flush,
    input  logic       trap_raise,
    input  logic       ftrap_raise,
    input  logic       trap_squash,
    input  logic       tc_squash,
    input  logic       rob_squash_done,
    output logic       commit_en,
    output logic       retire,
    output logic       flush_req,
    output logic       squash_all,
    output logic       flush_fire,
    output thr_state_e state
);
    thr_state_e state_n;
    logic       ext_squash;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Outputs
    always_comb begin
        ext_squash = !takeover && (trap_squash || tc_squash);
        flush_fire = !takeover && (state == ST_FLUSH_PEND) && !trap_squash && !tc_squash;
        squash_all = ext_squash || flush_fire;
        commit_en  = !takeover && (state == ST_IDLE) && !trap_squash && !tc_squash
                     && !trap_raise && !ftrap_raise;
        retire     = commit_en && head_valid;
        flush_req  = retire && head_flush;
    end

    // Next state
    always_comb begin
        state_n = state;
        if (takeover) begin
            state_n = ST_IDLE;
        end else if (squash_all) begin
            state_n = ST_ROB_SQUASH;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (trap_raise)       state_n = ST_TRAP_WAIT;
                    else if (ftrap_raise) state_n = ST_FTRAP_WAIT;
                    else if (flush_req)   state_n = ST_FLUSH_PEND;
                end
                ST_ROB_SQUASH: if (rob_squash_done) state_n = ST_IDLE;
                ST_TRAP_WAIT:  state_n = ST_TRAP_WAIT;
                ST_FTRAP_WAIT: state_n = ST_FTRAP_WAIT;
                ST_FLUSH_PEND: state_n = ST_ROB_SQUASH;
                default:       state_n = ST_IDLE;
            endcase
        end
    end

    assert_enter_pend_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && head_flush && !takeover) |=> (state == ST_FLUSH_PEND));

    assert_pend_no_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLUSH_PEND) |-> !retire);

    assert_pend_squashes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLUSH_PEND && !takeover) |-> squash_all);

    assert_fire_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flush_fire |=> !flush_fire);

    assert_no_commit_squash_R4: assert property (@(posedge clk) disable iff (!rst_n)
        squash_all |-> !retire);

    assert_rob_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ROB_SQUASH && !rob_squash_done && !squash_all && !takeover)
        |=> (state == ST_ROB_SQUASH));

    assert_trap_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRAP_WAIT || state == ST_FTRAP_WAIT) |-> !commit_en);
endmodule

// File: rtl/commit_flush_ctrl.sv
module commit_flush_ctrl
    import cfc_pkg::*;
#(
    parameter int THREADS = 2,
    parameter int SEQ_W   = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         takeover,
    input  logic [THREADS-1:0]           head_valid,
    input  logic [THREADS-1:0]           head_flush,
    input  logic [THREADS*SEQ_W-1:0]     head_seq,
    input  logic [THREADS-1:0]           trap_raise,
    input  logic [THREADS-1:0]           ftrap_raise,
    input  logic [THREADS-1:0]           trap_squash,
    input  logic [THREADS-1:0]           tc_squash,
    input  logic [THREADS-1:0]           rob_squash_done,
    output logic [THREADS-1:0]           commit_en,
    output logic [THREADS-1:0]           retire,
    output logic [THREADS-1:0]           squash_all,
    output logic [THREADS-1:0]           restart_vld,
    output logic [THREADS*SEQ_W-1:0]     restart_seq,
    output logic [THREADS-1:0]           activity,
    output logic [THREADS*STATE_W-1:0]   thread_state
);
    localparam int TOT_SEQ_W = THREADS * SEQ_W;

    logic [THREADS-1:0]   flush_req;
    logic [THREADS-1:0]   flush_fire;
    logic [THREADS-1:0]   tag_vld;
    logic [TOT_SEQ_W-1:0] tag_seq;

    for (genvar t = 0; t < THREADS; t++) begin : g_thr
        thr_state_e st;
        logic       clr;

        cfc_thread_fsm u_fsm (
            .clk             (clk),
            .rst_n           (rst_n),
            .takeover        (takeover),
            .head_valid      (head_valid[t]),
            .head_flush      (head_flush[t]),
            .trap_raise      (trap_raise[t]),
            .ftrap_raise     (ftrap_raise[t]),
            .trap_squash     (trap_squash[t]),
            .tc_squash       (tc_squash[t]),
            .rob_squash_done (rob_squash_done[t]),
            .commit_en       (commit_en[t]),
            .retire          (retire[t]),
            .flush_req       (flush_req[t]),
            .squash_all      (squash_all[t]),
            .flush_fire      (flush_fire[t]),
            .state           (st)
        );

        assign clr = takeover || squash_all[t];

        cfc_tag_latch #(.SEQ_W(SEQ_W)) u_tag (
            .clk      (clk),
            .rst_n    (rst_n),
            .capture  (flush_req[t]),
            .cap_seq  (head_seq[t*SEQ_W +: SEQ_W]),
            .clear    (clr),
            .held_vld (tag_vld[t]),
            .held_seq (tag_seq[t*SEQ_W +: SEQ_W])
        );

        assign restart_vld[t]                 = flush_fire[t];
        assign activity[t]                    = flush_fire[t];
        assign restart_seq[t*SEQ_W +: SEQ_W]  = flush_fire[t] ? tag_seq[t*SEQ_W +: SEQ_W] : '0;
        assign thread_state[t*STATE_W +: STATE_W] = st;

        // A flush squash always presents a latched tag
        assert_tag_present_R3: assert property (@(posedge clk) disable iff (!rst_n)
            restart_vld[t] |-> tag_vld[t]);

        // A trap or context-write squash leaves no stale tag behind
        assert_ext_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (squash_all[t] && !restart_vld[t]) |=> !tag_vld[t]);
    end
endmodule

// File: tb/tb_commit_flush_ctrl.sv
`timescale 1ns/1ps
module tb_commit_flush_ctrl;
    localparam int T  = 2;
    localparam int SW = 16;

    typedef struct packed {
        logic [7:0]    thr;
        logic          rv;
        logic [SW-1:0] seq;
    } sq_item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic takeover;
    logic [T-1:0] hv, hf, trp, ftrp, tsq, csq, done;
    logic [T*SW-1:0] hseq;
    logic [T-1:0] commit_en, retire, squash_all, restart_vld, activity;
    logic [T*SW-1:0] restart_seq;
    logic [T*3-1:0] thread_state;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    sq_item_t expq[$];

    always #2 clk = ~clk;

    commit_flush_ctrl #(.THREADS(T), .SEQ_W(SW)) dut (
        .clk(clk), .rst_n(rst_n), .takeover(takeover),
        .head_valid(hv), .head_flush(hf), .head_seq(hseq),
        .trap_raise(trp), .ftrap_raise(ftrp), .trap_squash(tsq),
        .tc_squash(csq), .rob_squash_done(done),
        .commit_en(commit_en), .retire(retire), .squash_all(squash_all),
        .restart_vld(restart_vld), .restart_seq(restart_seq),
        .activity(activity), .thread_state(thread_state)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clr();
        takeover = 1'b0;
        hv = '0; hf = '0; trp = '0; ftrp = '0; tsq = '0; csq = '0; done = '0;
        hseq = '0;
    endtask

    task automatic nxt();
        @(negedge clk);
        clr();
    endtask

    task automatic push(int thr, logic rv, logic [SW-1:0] seq);
        sq_item_t it;
        it.thr = 8'(thr);
        it.rv = rv;
        it.seq = seq;
        expq.push_back(it);
    endtask

    task automatic flag_head(int thr, logic [SW-1:0] seq);
        hv[thr] = 1'b1;
        hf[thr] = 1'b1;
        hseq[thr*SW +: SW] = seq;
    endtask

    function automatic logic [2:0] st(int thr);
        return thread_state[thr*3 +: 3];
    endfunction

    // Monitor: every squash pulse is matched against the scoreboard queue
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n) begin
                for (int t = 0; t < T; t++) begin
                    if (squash_all[t]) begin
                        if (expq.size() == 0) begin
                            checks++;
                            failures++;
                            $display("FAIL R3 unexpected squash thread=%0d actual=1 expected=0", t);
                        end else begin
                            sq_item_t e;
                            e = expq.pop_front();
                            chk("R3 squash thread", 32'(t), 32'(e.thr));
                            chk("R5 restart valid", 32'(restart_vld[t]), 32'(e.rv));
                            chk("R5 activity", 32'(activity[t]), 32'(e.rv));
                            if (e.rv) chk("R3 restart seq", 32'(restart_seq[t*SW +: SW]), 32'(e.seq));
                        end
                    end
                end
            end
        end
    end

    initial begin
        #800000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        clr();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 state0", 32'(st(0)), 0);
        chk("R1 state1", 32'(st(1)), 0);
        chk("R1 commit_en", 32'(commit_en), 32'h3);
        chk("R1 squash", 32'(squash_all), 0);

        // R2/R3/R8 basic flush after retire
        nxt(); flag_head(0, 16'h1234); hv[1] = 1'b1; push(0, 1'b1, 16'h1234);
        #1;
        chk("R2 flagged retire", 32'(retire[0]), 1);
        chk("R4 no squash on retire", 32'(squash_all[0]), 0);
        nxt(); hv = 2'b11; hseq[0 +: SW] = 16'h1235;
        #1;
        chk("R2 pending state", 32'(st(0)), 4);
        chk("R2 no retire pending", 32'(retire[0]), 0);
        chk("R3 restart valid", 32'(restart_vld[0]), 1);
        chk("R3 activity", 32'(activity[0]), 1);
        chk("R8 other thread retires", 32'(retire[1]), 1);
        nxt(); hv[0] = 1'b1;
        #1;
        chk("R3 rob squash state", 32'(st(0)), 1);
        chk("R3 restart one cycle", 32'(restart_vld[0]), 0);
        chk("R6 no retire", 32'(retire[0]), 0);
        nxt(); hv[0] = 1'b1;
        #1;
        chk("R6 hold", 32'(st(0)), 1);
        chk("R6 commit off", 32'(commit_en[0]), 0);
        nxt(); done[0] = 1'b1;
        nxt(); hv[0] = 1'b1;
        #1;
        chk("R6 back to idle", 32'(st(0)), 0);
        chk("R6 retire resumes", 32'(retire[0]), 1);

        // R5 context-write squash outranks pending flush
        nxt(); flag_head(0, 16'h0042); push(0, 1'b0, 16'h0);
        nxt(); csq[0] = 1'b1;
        #1;
        chk("R5 squash from tc", 32'(squash_all[0]), 1);
        chk("R5 no restart tag", 32'(restart_vld[0]), 0);
        nxt(); done[0] = 1'b1;
        #1;
        chk("R5 rob squash", 32'(st(0)), 1);
        nxt(); flag_head(0, 16'h0050); push(0, 1'b1, 16'h0050);
        #1;
        chk("R9 fresh request retires", 32'(retire[0]), 1);
        nxt();
        #1;
        chk("R9 new tag", 32'(restart_seq[0 +: SW]), 32'h0050);
        nxt(); done[0] = 1'b1;
        nxt();

        // R5 trap beats tc and blocks flagged retire
        nxt(); flag_head(0, 16'h0060); tsq[0] = 1'b1; csq[0] = 1'b1; push(0, 1'b0, 16'h0);
        #1;
        chk("R5 flagged head blocked", 32'(retire[0]), 0);
        chk("R5 trap squash", 32'(squash_all[0]), 1);
        nxt(); done[0] = 1'b1;
        nxt();
        #1;
        chk("R5 no flush pending", 32'(st(0)), 0);

        // R7 trap waits
        nxt(); trp[1] = 1'b1; hv[1] = 1'b1;
        #1;
        chk("R7 raise blocks retire", 32'(retire[1]), 0);
        nxt(); hv[1] = 1'b1;
        #1;
        chk("R7 trap wait", 32'(st(1)), 2);
        chk("R7 commit off", 32'(commit_en[1]), 0);
        nxt(); tsq[1] = 1'b1; push(1, 1'b0, 16'h0);
        nxt(); done[1] = 1'b1;
        #1;
        chk("R7 to rob squash", 32'(st(1)), 1);
        nxt(); ftrp[1] = 1'b1;
        nxt();
        #1;
        chk("R7 fetch trap wait", 32'(st(1)), 3);
        nxt(); tsq[1] = 1'b1; push(1, 1'b0, 16'h0);
        nxt(); done[1] = 1'b1;
        nxt();
        #1;
        chk("R7 idle again", 32'(st(1)), 0);

        // R1 takeover drops a pending flush
        nxt(); flag_head(0, 16'h0077);
        nxt(); takeover = 1'b1;
        #1;
        chk("R1 takeover no squash", 32'(squash_all[0]), 0);
        chk("R1 takeover no commit", 32'(commit_en[0]), 0);
        nxt();
        #1;
        chk("R1 takeover idle", 32'(st(0)), 0);
        chk("R1 takeover no restart", 32'(restart_vld[0]), 0);
        nxt(); flag_head(0, 16'h0099); push(0, 1'b1, 16'h0099);
        nxt();
        #1;
        chk("R1 tag after takeover", 32'(restart_seq[0 +: SW]), 32'h0099);
        nxt(); done[0] = 1'b1;
        repeat (3) nxt();
        #1;
        chk("R3 all squashes seen", 32'(expq.size()), 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule